// File: doc/BRIEF.md
# Video Memory CPU Slot Arbiter

This block places CPU reads and writes to video memory into the free cycles left over by the display fetch. A built-in raster timer counts memory-clock cycles within a scan line and scan lines within a frame. All counting advances only on cycles where the pixel-clock enable is high. On visible lines the CPU gets one cycle in every `SLOT_PERIOD`. On blanking lines, and whenever the display is switched off, every enabled cycle is open to the CPU.

The CPU side is not synchronised to this schedule. It offers one request at a time on a valid/ready handshake. The arbiter holds that single request until an open slot arrives. It then drives the RAM port for one cycle and, two cycles later, pulses an acknowledge. For a read, the data arrives together with that acknowledge.

The CPU may not hold a request while waiting: a request is offered for exactly one cycle. A valid offered while ready is low is not back-pressure. It is an overrun: the new request is discarded and a flag is raised for one cycle. The request already held is not disturbed.

Top module: `vram_slot_arbiter`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_ack`, `overrun` and `ram_en` are 0. The line, cycle and slot-phase counters all start at 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is then low from the next cycle until the cycle in which `rsp_ack` is high, and it is high again in that cycle.
- R3: On a visible line (line index below `V_ACTIVE`) with `disp_en`=1, a held request is granted only in a cycle with `pix_ce`=1 and slot phase equal to `SLOT_PERIOD-1`. The slot phase counts enabled cycles and restarts at 0 at the start of every line. It is granted in the first such cycle after acceptance.
- R4: On a blanking line (line index `V_ACTIVE` to `V_TOTAL-1`), a held request is granted in the first cycle with `pix_ce`=1.
- R5: With `disp_en`=0, a held request is granted in the first cycle with `pix_ce`=1, whatever the line.
- R6: While `pix_ce`=0, the raster counters hold and no grant happens.
- R7: A write grant drives `ram_en`=1 and `ram_we`=1 with the held address and data for one cycle. `rsp_ack` pulses for one cycle, two cycles after the grant.
- R8: A read grant drives `ram_en`=1 and `ram_we`=0. The RAM returns data the cycle after `ram_en`. `rsp_rdata` carries that byte in the `rsp_ack` cycle, two cycles after the grant, and holds it afterwards.
- R9: A `req_valid` seen while `req_ready` is low gives `overrun`=1 in the next cycle. That request is dropped and never reaches the RAM.
- R10: Each accepted request produces exactly one `ram_en` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_ce | input | 1 | Pixel-clock enable; raster timing advances only when high |
| disp_en | input | 1 | Display enable; 0 opens every enabled cycle to the CPU |
| req_valid | input | 1 | CPU request offered this cycle |
| req_ready | output | 1 | Arbiter can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Video memory address |
| req_wdata | input | DATA_W | Write data |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with `rsp_ack` |
| overrun | output | 1 | One-cycle flag for a dropped request |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, one cycle after `ram_en` |

## Verification
The bench builds the arbiter with 12 cycles per line, 4 lines per frame, 2 visible lines and a slot period of 4, on 8-bit addresses and data. A whole frame therefore lasts 48 cycles, so a short request table already crosses visible and blanking lines and lands requests at every slot phase. Grant timing is predicted from a small raster model in the bench. The small frame also makes it cheap to line up an overrun or a blanking-line request on purpose.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;
  // Lifecycle of the single request slot.
  typedef enum logic [1:0] {
    REQ_EMPTY  = 2'd0,
    REQ_HELD   = 2'd1,
    REQ_ISSUED = 2'd2
  } req_phase_e;

  // Width helper that never returns zero.
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vram_slot_timer.sv
module vram_slot_timer
  import vram_arb_pkg::*;
#(
  parameter int H_TOTAL     = 342,
  parameter int V_TOTAL     = 262,
  parameter int V_ACTIVE    = 192,
  parameter int SLOT_PERIOD = 86
) (
  input  logic clk,
  input  logic rst,
  input  logic pix_ce,
  input  logic disp_en,
  output logic vblank,
  output logic slot_open
);
  localparam int HW = cnt_width(H_TOTAL);
  localparam int VW = cnt_width(V_TOTAL);
  localparam int PW = cnt_width(SLOT_PERIOD);
  localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_VIS   = VW'(V_ACTIVE);
  localparam logic [PW-1:0] PH_LAST = PW'(SLOT_PERIOD - 1);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic [PW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q  <= '0;
      v_q  <= '0;
      ph_q <= '0;
    end else if (pix_ce) begin
      if (h_q == H_LAST) begin
        h_q  <= '0;
        ph_q <= '0;
        v_q  <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
      end else begin
        h_q  <= h_q + 1'b1;
        ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      end
    end
  end

  logic cpu_slot;
  assign vblank    = (v_q >= V_VIS);
  assign cpu_slot  = (ph_q == PH_LAST);
  assign slot_open = pix_ce & (~disp_en | vblank | cpu_slot);
endmodule

// File: rtl/vram_req_holder.sv
module vram_req_holder #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              in_flight,
  input  logic              issue,
  output logic              req_ready,
  output logic              overrun,
  output logic              pend_q,
  output logic              pend_we,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [DATA_W-1:0] pend_data
);
  logic accept;
  assign req_ready = ~pend_q & ~in_flight;
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      pend_we   <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      overrun   <= 1'b0;
    end else begin
      overrun <= req_valid & ~req_ready;
      if (accept) begin
        pend_q    <= 1'b1;
        pend_we   <= req_write;
        pend_addr <= req_addr;
        pend_data <= req_wdata;
      end else if (issue) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vram_access_ctrl.sv
module vram_access_ctrl #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pend_q,
  input  logic              pend_we,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic [DATA_W-1:0] pend_data,
  input  logic              slot_open,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              in_flight,
  output logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic flight_we_q;

  assign ram_en    = pend_q & slot_open;
  assign ram_we    = ram_en & pend_we;
  assign ram_addr  = pend_addr;
  assign ram_wdata = pend_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_flight   <= 1'b0;
      flight_we_q <= 1'b0;
      rsp_ack     <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      in_flight   <= ram_en;
      flight_we_q <= ram_we;
      rsp_ack     <= in_flight;
      if (in_flight && !flight_we_q) rsp_rdata <= ram_rdata;
    end
  end
endmodule

// File: rtl/vram_slot_arbiter.sv
module vram_slot_arbiter #(
  parameter int H_TOTAL     = 342,
  parameter int V_TOTAL     = 262,
  parameter int V_ACTIVE    = 192,
  parameter int SLOT_PERIOD = 86,   // ~8 us at a 10.74 MHz memory clock
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_ce,
  input  logic              disp_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              overrun,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  logic              vblank, slot_open, in_flight;
  logic              pend_q, pend_we;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;

  vram_slot_timer #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
    .V_ACTIVE(V_ACTIVE), .SLOT_PERIOD(SLOT_PERIOD)
  ) u_timer (
    .clk(clk), .rst(rst), .pix_ce(pix_ce), .disp_en(disp_en),
    .vblank(vblank), .slot_open(slot_open)
  );

  vram_req_holder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .in_flight(in_flight),
    .issue(ram_en), .req_ready(req_ready), .overrun(overrun),
    .pend_q(pend_q), .pend_we(pend_we), .pend_addr(pend_addr),
    .pend_data(pend_data)
  );

  vram_access_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .pend_q(pend_q), .pend_we(pend_we),
    .pend_addr(pend_addr), .pend_data(pend_data), .slot_open(slot_open),
    .ram_rdata(ram_rdata), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .in_flight(in_flight),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/vram_slot_arbiter_checker.sv
module vram_slot_arbiter_checker (
  input logic clk,
  input logic rst,
  input logic pix_ce,
  input logic disp_en,
  input logic req_valid,
  input logic req_ready,
  input logic ram_en,
  input logic rsp_ack,
  input logic overrun,
  input logic pend,
  input logic vblank
);
  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);
  assert_overrun_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> overrun);
  assert_ce_gate_R6: assert property (@(posedge clk) disable iff (rst)
    ram_en |-> pix_ce);
  assert_display_off_R5: assert property (@(posedge clk) disable iff (rst)
    pix_ce && !disp_en && pend |-> ram_en);
  assert_blank_line_R4: assert property (@(posedge clk) disable iff (rst)
    pix_ce && vblank && pend |-> ram_en);
  assert_ack_delay_R7: assert property (@(posedge clk) disable iff (rst)
    ram_en |-> ##2 rsp_ack);
  assert_single_access_R10: assert property (@(posedge clk) disable iff (rst)
    ram_en |=> !ram_en);
endmodule

bind vram_slot_arbiter vram_slot_arbiter_checker u_chk (
  .clk(clk), .rst(rst), .pix_ce(pix_ce), .disp_en(disp_en),
  .req_valid(req_valid), .req_ready(req_ready), .ram_en(ram_en),
  .rsp_ack(rsp_ack), .overrun(overrun), .pend(pend_q), .vblank(vblank)
);

// File: tb/vram_slot_arbiter_test.sv
module vram_slot_arbiter_test;
  localparam int HT = 12, VT = 4, VA = 2, SP = 4;

  logic clk = 1'b0, rst = 1'b1, pix_ce = 1'b1, disp_en = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_ack, overrun, ram_en, ram_we;
  logic [7:0] rsp_rdata, ram_addr, ram_wdata;
  logic [7:0] ram_q;
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  int cyc = 0, en_count = 0, ack_count = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vram_slot_arbiter #(.H_TOTAL(HT), .V_TOTAL(VT), .V_ACTIVE(VA),
    .SLOT_PERIOD(SP), .ADDR_W(8), .DATA_W(8)) uut (
    .clk(clk), .rst(rst), .pix_ce(pix_ce), .disp_en(disp_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata), .overrun(overrun), .ram_en(ram_en),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_q));

  // Behavioural RAM, one-cycle read latency.
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      else ram_q <= mem[ram_addr];
    end
  end

  // Enabled-cycle count since reset = raster position of the current cycle.
  always @(posedge clk) begin
    if (!rst && pix_ce) cyc <= cyc + 1;
    if (!rst && ram_en) en_count <= en_count + 1;
    if (!rst && rsp_ack) ack_count <= ack_count + 1;
  end

  function automatic bit slot_at(int k, bit d);
    int h = k % HT;
    int v = (k / HT) % VT;
    return !d || v >= VA || (h % SP) == SP - 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Fields: [21] write, [20:13] addr, [12:5] data, [4] disp_en, [3:0] idle gap
  localparam logic [21:0] VEC [10] = '{
    {1'b1, 8'h10, 8'hA5, 1'b1, 4'd0},
    {1'b1, 8'h11, 8'h3C, 1'b1, 4'd3},
    {1'b0, 8'h10, 8'h00, 1'b1, 4'd1},
    {1'b1, 8'h20, 8'h77, 1'b0, 4'd2},
    {1'b0, 8'h11, 8'h00, 1'b0, 4'd0},
    {1'b0, 8'h20, 8'h00, 1'b1, 4'd5},
    {1'b1, 8'h10, 8'h0F, 1'b1, 4'd7},
    {1'b0, 8'h10, 8'h00, 1'b0, 4'd1},
    {1'b1, 8'h30, 8'h99, 1'b1, 4'd11},
    {1'b0, 8'h30, 8'h00, 1'b1, 4'd2}
  };

  // Offer one request now (at a negedge); return the cycle index it was seen in.
  task automatic offer(bit wr, logic [7:0] a, logic [7:0] d, output int n);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    n = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_ack(output int at);
    int guard = 0;
    while (!rsp_ack && guard < 500) begin @(negedge clk); guard++; end
    at = cyc;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(rsp_ack == 1'b0 && overrun == 1'b0 && ram_en == 1'b0,
          "R1 idle outputs", {rsp_ack, overrun, ram_en}, 0);
    rst = 1'b0;

    // Vector table: grant timing from the raster model, data from a shadow copy.
    for (int i = 0; i < 10; i++) begin
      bit wr, d;
      logic [7:0] a, wd;
      int n, m, at, en0;
      wr = VEC[i][21]; a = VEC[i][20:13]; wd = VEC[i][12:5]; d = VEC[i][4];
      disp_en = d;
      repeat (VEC[i][3:0]) @(negedge clk);
      en0 = en_count;
      offer(wr, a, wd, n);
      check(req_ready == 1'b0, "R2 ready drops", req_ready, 0);
      m = n + 1;
      while (!slot_at(m, d)) m++;
      wait_ack(at);
      check(at == m + 2, "R3 R4 R5 grant slot", at, m + 2);
      check(req_ready == 1'b1, "R2 ready with ack", req_ready, 1);
      check(en_count - en0 == 1, "R10 one access", en_count - en0, 1);
      if (wr) begin
        shadow[a] = wd;
        check(mem[a] == wd, "R7 write data", mem[a], wd);
      end else begin
        check(rsp_rdata == shadow[a], "R8 read data", rsp_rdata, shadow[a]);
      end
      @(negedge clk);
      check(rsp_ack == 1'b0, "R7 ack one cycle", rsp_ack, 0);
      if (!wr) check(rsp_rdata == shadow[a], "R8 data held", rsp_rdata, shadow[a]);
    end

    // R6: pix_ce low freezes the raster and blocks grants.
    begin
      int n, c0, a0, cnt;
      disp_en = 1'b0;
      pix_ce = 1'b0;
      c0 = cyc; a0 = ack_count;
      offer(1'b1, 8'h50, 8'h5A, n);
      repeat (10) @(negedge clk);
      check(ack_count == a0 && mem[8'h50] == 8'h00, "R6 no grant", ack_count - a0, 0);
      check(cyc == c0, "R6 raster frozen", cyc, c0);
      pix_ce = 1'b1;
      cnt = 0;
      while (!rsp_ack && cnt < 20) begin @(negedge clk); cnt++; end
      check(cnt == 2, "R6 grant on resume", cnt, 2);
      check(mem[8'h50] == 8'h5A, "R6 write landed", mem[8'h50], 8'h5A);
      shadow[8'h50] = 8'h5A;
    end

    // R4: blanking line with display on grants at once.
    begin
      int n, at;
      disp_en = 1'b1;
      @(negedge clk);
      while (((cyc / HT) % VT) < VA || (cyc % HT) > 6) @(negedge clk);
      offer(1'b0, 8'h50, 8'h00, n);
      wait_ack(at);
      check(at == n + 3, "R4 blank line latency", at, n + 3);
      check(rsp_rdata == 8'h5A, "R8 blank read", rsp_rdata, 8'h5A);
    end

    // R9: second offer while busy is flagged and dropped.
    begin
      int n, n2, at, a0;
      @(negedge clk);
      while (((cyc / HT) % VT) >= VA || (cyc % HT) % SP != 0) @(negedge clk);
      a0 = ack_count;
      offer(1'b1, 8'h60, 8'h11, n);
      offer(1'b1, 8'h61, 8'h22, n2);
      check(overrun == 1'b1, "R9 overrun flag", overrun, 1);
      @(negedge clk);
      check(overrun == 1'b0, "R9 flag one cycle", overrun, 0);
      wait_ack(at);
      check(at == n + 5, "R3 active slot latency", at, n + 5);
      repeat (20) @(negedge clk);
      check(ack_count - a0 == 1, "R9 single completion", ack_count - a0, 1);
      check(mem[8'h61] == 8'h00, "R9 dropped write", mem[8'h61], 0);
      check(mem[8'h60] == 8'h11, "R9 held write kept", mem[8'h60], 8'h11);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule